// File: doc/BRIEF.md
# Transceiver Modem State Sequencer

This block steps a contactless reader through one transmit-then-receive exchange. A transceive command arms it, and a start-send command begins the exchange. It then passes through a timed wait before transmitting and a second timed wait before receiving. After that it hunts for an incoming frame, receives it, and re-arms for the next exchange. Each wait has its own programmable minimum length in clock ticks. When a configuration bit is set, each wait also holds until the RF field is present.

The current phase is exposed as a fixed 3-bit code that a status register can read. Two enables follow the phase: one drives the transmitter and one drives the receiver. Done and start-of-frame pulses from those datapaths move the sequence on. A synchronous idle command returns the block to its rest state from any phase. Modulation, bit coding and the analog front end belong to other blocks.

Top module: `modem_seq_top`

## Requirements
- R1: After reset, `state_code` is 3'b000 (idle), and `tx_en` and `rx_en` are low.
- R2: In idle, `cmd_transceive` moves the code to 3'b001 on the next edge. `start_send`, `tx_done`, `rx_sof` and `rx_end` have no effect in idle.
- R3: In 3'b001, `start_send` moves the code to 3'b010 (transmit wait) on the next edge. `tx_done` has no effect in 3'b001.
- R4: With `wait_rf_en` low, or with the field present throughout, code 3'b010 lasts exactly N+1 cycles. N is `tx_wait_val` sampled on the edge that enters the state. The level of `rf_present` has no effect when `wait_rf_en` is low.
- R5: With `wait_rf_en` high, codes 3'b010 and 3'b100 are held while `rf_present` is low. They leave on the first edge at which both the timer has expired and the field is present.
- R6: Code 3'b011 (transmitting) lasts until a `tx_done` pulse, then moves to 3'b100. `tx_en` is high exactly while the code is 3'b011.
- R7: With `wait_rf_en` low, or with the field present throughout, code 3'b100 lasts exactly M+1 cycles. M is `rx_wait_val` sampled on entry. The state then moves to 3'b101.
- R8: Code 3'b101 moves to 3'b110 on `rx_sof`, and 3'b110 returns to 3'b001 on `rx_end`. `rx_en` is high exactly while the code is 3'b101 or 3'b110.
- R9: `cmd_idle` forces code 3'b000 on the next edge from any state, and it wins over every other input, including `cmd_transceive`.
- R10: Code 3'b111 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_transceive | input | 1 | Arm pulse: idle to waiting for start-send |
| cmd_idle | input | 1 | Force idle (highest priority) |
| start_send | input | 1 | Start the exchange from the armed state |
| rf_present | input | 1 | RF field currently detected |
| wait_rf_en | input | 1 | Both waits also hold for the field |
| tx_wait_val | input | WAIT_W | Minimum transmit-wait ticks |
| rx_wait_val | input | WAIT_W | Minimum receive-wait ticks |
| tx_done | input | 1 | Transmitter finished pulse |
| rx_sof | input | 1 | Receiver saw start of frame |
| rx_end | input | 1 | Receiver finished pulse |
| state_code | output | 3 | Current phase code |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |

## Verification
The bench builds the block with the default 8-bit wait width. This allows a programmed wait of 200 ticks to be checked next to waits of 0, 2, 3 and 4 ticks. The zero case shows that the one-cycle floor is kept. The large value shows that the counter holds across many cycles without wrapping. With RF gating on, the field is held off for a chosen number of cycles. This checks both the case where the field decides the exit and the case where the timer does.

// File: rtl/modem_seq_pkg.sv
// Shared types for the modem state sequencer.
// The state encoding is visible to software and must not change.
package modem_seq_pkg;
    typedef enum logic [2:0] {
        MS_IDLE   = 3'b000,
        MS_ARMED  = 3'b001,
        MS_TXWAIT = 3'b010,
        MS_TX     = 3'b011,
        MS_RXWAIT = 3'b100,
        MS_RXHUNT = 3'b101,
        MS_RX     = 3'b110
    } mstate_e;

    localparam int NUM_WAITS = 2;
    localparam int WAIT_TX   = 0;
    localparam int WAIT_RX   = 1;
endpackage

// File: rtl/wait_timer.sv
// Down-counting minimum-wait timer.
// A load pulse captures the programmed tick count. The counter then
// decrements to zero and holds there. expired is high while the count is zero.
// Assumes the load is raised on the edge that enters the wait state.
module wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Count register: load takes priority, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Expiry flag derived from the count.
    always_comb expired = (cnt == '0);

    // R4
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

    // R7
    expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);
endmodule

// File: rtl/modem_fsm.sv
// Phase controller for one transceive exchange.
// It walks armed -> tx wait -> transmitting -> rx wait -> hunting ->
// receiving -> armed. Each wait exits only when its timer has expired and,
// if gating is on, the field is present. It asks the timers to load on
// entry to their wait state. Assumes the datapath inputs are one-cycle pulses.
module modem_fsm
    import modem_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_transceive,
    input  logic                 cmd_idle,
    input  logic                 start_send,
    input  logic                 rf_present,
    input  logic                 wait_rf_en,
    input  logic                 tx_done,
    input  logic                 rx_sof,
    input  logic                 rx_end,
    input  logic [NUM_WAITS-1:0] tmr_expired,
    output mstate_e              st,
    output logic [NUM_WAITS-1:0] tmr_load,
    output logic                 tx_en,
    output logic                 rx_en
);
    mstate_e st_nxt;
    logic    field_ok;

    // Field qualifier: ignored unless gating is enabled.
    always_comb field_ok = !wait_rf_en || rf_present;

    // Next-state selection, with the idle command overriding everything.
    always_comb begin
        st_nxt = st;
        if (cmd_idle) begin
            st_nxt = MS_IDLE;
        end else begin
            case (st)
                MS_IDLE:   if (cmd_transceive) st_nxt = MS_ARMED;
                MS_ARMED:  if (start_send)     st_nxt = MS_TXWAIT;
                MS_TXWAIT: if (tmr_expired[WAIT_TX] && field_ok) st_nxt = MS_TX;
                MS_TX:     if (tx_done)        st_nxt = MS_RXWAIT;
                MS_RXWAIT: if (tmr_expired[WAIT_RX] && field_ok) st_nxt = MS_RXHUNT;
                MS_RXHUNT: if (rx_sof)         st_nxt = MS_RX;
                MS_RX:     if (rx_end)         st_nxt = MS_ARMED;
                default:                       st_nxt = MS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= MS_IDLE;
        else        st <= st_nxt;
    end

    // Timer load requests on entry to each wait state.
    always_comb begin
        tmr_load[WAIT_TX] = (st != MS_TXWAIT) && (st_nxt == MS_TXWAIT);
        tmr_load[WAIT_RX] = (st != MS_RXWAIT) && (st_nxt == MS_RXWAIT);
    end

    // Datapath enables decoded from the phase.
    always_comb begin
        tx_en = (st == MS_TX);
        rx_en = (st == MS_RXHUNT) || (st == MS_RX);
    end

    // R10
    no_unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st != 3'b111);

    // R9
    idle_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_idle |=> (st == MS_IDLE));

    // R5
    rf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MS_TXWAIT && wait_rf_en && !rf_present && !cmd_idle) |=> (st == MS_TXWAIT));

    // R4
    tx_timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MS_TXWAIT && !tmr_expired[WAIT_TX] && !cmd_idle) |=> (st == MS_TXWAIT));

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MS_TX && !tx_done && !cmd_idle) |=> (st == MS_TX));

    // R8
    sof_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MS_RXHUNT && rx_sof && !cmd_idle) |=> (st == MS_RX));
endmodule

// File: rtl/modem_seq_top.sv
// Top of the modem state sequencer.
// It joins the phase controller to one minimum-wait timer per wait phase
// and exposes the 3-bit phase code and the datapath enables.
module modem_seq_top
    import modem_seq_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_transceive,
    input  logic              cmd_idle,
    input  logic              start_send,
    input  logic              rf_present,
    input  logic              wait_rf_en,
    input  logic [WAIT_W-1:0] tx_wait_val,
    input  logic [WAIT_W-1:0] rx_wait_val,
    input  logic              tx_done,
    input  logic              rx_sof,
    input  logic              rx_end,
    output logic [2:0]        state_code,
    output logic              tx_en,
    output logic              rx_en
);
    mstate_e                st;
    logic [NUM_WAITS-1:0]   tmr_load;
    logic [NUM_WAITS-1:0]   tmr_expired;
    logic [WAIT_W-1:0]      wait_val [NUM_WAITS];

    // Route the programmed values to their timers.
    always_comb begin
        wait_val[WAIT_TX] = tx_wait_val;
        wait_val[WAIT_RX] = rx_wait_val;
    end

    modem_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_transceive (cmd_transceive),
        .cmd_idle       (cmd_idle),
        .start_send     (start_send),
        .rf_present     (rf_present),
        .wait_rf_en     (wait_rf_en),
        .tx_done        (tx_done),
        .rx_sof         (rx_sof),
        .rx_end         (rx_end),
        .tmr_expired    (tmr_expired),
        .st             (st),
        .tmr_load       (tmr_load),
        .tx_en          (tx_en),
        .rx_en          (rx_en)
    );

    for (genvar g = 0; g < NUM_WAITS; g++) begin : g_tmr
        wait_timer #(.W(WAIT_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (tmr_load[g]),
            .load_val (wait_val[g]),
            .expired  (tmr_expired[g])
        );
    end

    // Publish the phase code.
    always_comb state_code = st;

    // R6
    tx_en_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (state_code == 3'b011));
endmodule

// File: tb/sim_modem_seq_top.sv
// Scoreboard bench. Driver tasks push the expected code sequence and the
// expected wait durations. A negedge monitor pops them as the code changes.
module sim_modem_seq_top;
    localparam int W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_transceive = 0, cmd_idle = 0, start_send = 0, rf_present = 0;
    logic wait_rf_en = 0, tx_done = 0, rx_sof = 0, rx_end = 0;
    logic [W-1:0] tx_wait_val = '0, rx_wait_val = '0;
    logic [2:0] state_code;
    logic tx_en, rx_en;

    int checks = 0, fails = 0;
    int exp_q[$];
    int len_q[$];
    bit mon_on = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    modem_seq_top #(.WAIT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_transceive(cmd_transceive), .cmd_idle(cmd_idle),
        .start_send(start_send), .rf_present(rf_present), .wait_rf_en(wait_rf_en),
        .tx_wait_val(tx_wait_val), .rx_wait_val(rx_wait_val), .tx_done(tx_done),
        .rx_sof(rx_sof), .rx_end(rx_end), .state_code(state_code), .tx_en(tx_en), .rx_en(rx_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: sequence, wait durations, enables.
    int prev = 0, run = 0;
    always @(negedge clk) if (mon_on) begin
        check("R6 tx_en", tx_en, state_code == 3);
        check("R8 rx_en", rx_en, state_code == 5 || state_code == 6);
        check("R10 code", state_code == 7, 0);
        if (state_code != prev) begin
            if (exp_q.size() == 0) check("R2 unexpected code", state_code, -1);
            else check("R2/R3/R8/R9 next code", state_code, exp_q.pop_front());
            if (prev == 2 || prev == 4) begin
                if (len_q.size() == 0) check("R4/R7 unexpected wait", run, -1);
                else check(prev == 2 ? "R4/R5 tx wait length" : "R7/R5 rx wait length",
                           run, len_q.pop_front());
            end
            prev = state_code;
            run = 1;
        end else run++;
    end

    task automatic pulse(input int sel);
        @(negedge clk);
        case (sel)
            0: cmd_transceive = 1; 1: cmd_idle = 1; 2: start_send = 1;
            3: tx_done = 1; 4: rx_sof = 1; default: rx_end = 1;
        endcase
        @(negedge clk);
        {cmd_transceive, cmd_idle, start_send, tx_done, rx_sof, rx_end} = '0;
    endtask

    task automatic wait_code(input int c);
        while (state_code != c) @(negedge clk);
    endtask

    function automatic int wlen(input int n, input bit gate, input int hold);
        if (!gate || hold == 0) return n + 1;
        return (hold > n + 1) ? hold : n + 1;
    endfunction

    // One full exchange. hold_x = cycles the field stays off inside the wait.
    task automatic exchange(input int n_tx, input int n_rx, input bit gate,
                            input int hold_tx, input int hold_rx);
        tx_wait_val = n_tx[W-1:0];
        rx_wait_val = n_rx[W-1:0];
        wait_rf_en = gate;
        foreach (exp_q[i]) ;
        exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3);
        exp_q.push_back(4); exp_q.push_back(5); exp_q.push_back(6);
        exp_q.push_back(1); exp_q.push_back(0);
        len_q.push_back(wlen(n_tx, gate, hold_tx));
        len_q.push_back(wlen(n_rx, gate, hold_rx));
        pulse(0);
        wait_code(1);
        repeat (2) @(negedge clk);
        pulse(3);                                   // R3: tx_done ignored when armed
        check("R3 tx_done ignored in 001", state_code, 1);
        rf_present = gate ? (hold_tx == 0) : 1'b0;  // R4: field level ignored when not gated
        pulse(2);
        wait_code(2);
        if (gate && hold_tx > 0) begin
            repeat (hold_tx - 1) @(negedge clk);
            rf_present = 1;
        end
        wait_code(3);
        repeat (3) @(negedge clk);
        rf_present = gate ? (hold_rx == 0) : 1'b0;
        pulse(3);
        wait_code(4);
        if (gate && hold_rx > 0) begin
            repeat (hold_rx - 1) @(negedge clk);
            rf_present = 1;
        end
        wait_code(5);
        repeat (3) @(negedge clk);
        pulse(4);
        wait_code(6);
        repeat (2) @(negedge clk);
        pulse(5);
        wait_code(1);
        pulse(1);
        wait_code(0);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset code", state_code, 0);
        check("R1 reset tx_en", tx_en, 0);
        check("R1 reset rx_en", rx_en, 0);
        rst_n = 1;
        mon_on = 1;
        @(negedge clk);

        // R2: inputs other than the transceive command ignored in idle
        pulse(2); pulse(3); pulse(4); pulse(5);
        check("R2 idle ignores datapath pulses", state_code, 0);

        // R4/R7 ungated, including a long wait
        exchange(3, 5, 0, 0, 0);
        exchange(200, 0, 0, 0, 0);
        // R5 gated: the field decides both exits
        exchange(2, 2, 1, 10, 7);
        // R5 gated with field already present: the timers decide
        exchange(0, 4, 1, 0, 0);
        // R5 gated: the field rises before the timer expires
        exchange(6, 6, 1, 3, 2);

        // R9: idle from transmitting, then idle beats transceive
        exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(0);
        len_q.push_back(1);
        tx_wait_val = 0; wait_rf_en = 0;
        pulse(0); wait_code(1); pulse(2); wait_code(3);
        pulse(1);
        check("R9 idle from 011", state_code, 0);
        @(negedge clk);
        cmd_idle = 1; cmd_transceive = 1;
        @(negedge clk);
        cmd_idle = 0; cmd_transceive = 0;
        check("R9 idle wins over transceive", state_code, 0);

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size() + len_q.size(), 0);
        finished = 1;
        summary();
    end
endmodule